// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port Controller

This block controls one eight-pin port of a microcontroller. Software reaches four per-pin control registers over a small register bus: an output latch, a direction mask, a pull-enable mask and a slew-enable mask. From those registers, and from the pins' own input levels, it builds the control signals for each pad: drive enable, drive level, pullup, pulldown and slew limiting. Any pin can be taken over by an on-chip peripheral. While a peripheral holds a pin, the peripheral sets the pad's direction and level. The direction mask still decides what software reads back from the output-latch address.

Pin levels pass through a two-stage synchronizer before they reach the read path. The register bus uses plain strobes and has no back-pressure. A write strobe is taken at the rising clock edge. A read strobe loads the read-data register at that same edge, so the data is available on the cycle after the strobe. No valid/ready handshake exists, because each access completes in a fixed single cycle.

The upper four pins are shared with a keyboard-wakeup function. When that function configures one of these pins for rising-edge detection, the pin's pull enable selects a pulldown instead of a pullup.

Top module: `gpio_port`

## Requirements
- R1: While reset is low and after it is released, all four registers, the read-data output and every pad control output are 0.
- R2: A write strobe loads bus_wdata into the register chosen by bus_addr (0 output latch, 1 direction, 2 pull enable, 3 slew enable) at the rising edge. A write to the output latch is always accepted, whether the pin is an input or is held by a peripheral.
- R3: A read strobe at a rising edge loads bus_rdata with the addressed register's value as it was before that edge. When no read strobe is present, bus_rdata holds its value.
- R4: A read of address 0 returns, for each bit, the latched value when the direction bit is 1. When the direction bit is 0, it returns the pin level sampled two rising edges before the read edge.
- R5: For a pin with per_own high, pad_oe follows per_oe and pad_out follows per_out. The read of address 0 is still selected by the direction bit.
- R6: For a pin with per_own low, pad_oe equals the direction bit and pad_out equals the latched output bit.
- R7: A pin's pull device is on only when its pull-enable bit is 1, its direction bit is 0 and pad_oe is 0. This also holds while a peripheral uses the pin as an input.
- R8: On bits 7 to 4, an active pull is routed to pad_pd when the matching kbd_rise bit (bit 0 maps to pin 4) is 1, and to pad_pu otherwise. Bits 3 to 0 never assert pad_pd. pad_pu and pad_pd are never both 1 for the same pin.
- R9: pad_slew for a pin is 1 exactly when its slew-enable bit is 1 and pad_oe is 1.
- R10: When a read and a write to the same address fall on the same edge, the read returns the value from before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 latch, 1 direction, 2 pull, 3 slew |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after the strobe |
| pin_in | input | 8 | Asynchronous pin levels from the pads |
| per_own | input | 8 | Per pin: a peripheral controls the pin |
| per_oe | input | 8 | Per pin: peripheral drive enable |
| per_out | input | 8 | Per pin: peripheral drive level |
| kbd_rise | input | 4 | Per upper pin: keyboard function detects rising edges |
| pad_oe | output | 8 | Pad driver enable |
| pad_out | output | 8 | Pad drive level |
| pad_pu | output | 8 | Pad pullup enable |
| pad_pd | output | 8 | Pad pulldown enable |
| pad_slew | output | 8 | Pad slew-limit enable |

## Verification
Two functions can coincide on one edge. The first is a register write that collides with a read of the same address, which could return the old or the new value. The second is a change to the direction mask on the same edge that the output-latch read samples it, which switches a bit between pin level and latch. The bench provokes both in a directed phase and then in a long random phase where every strobe and address is drawn each cycle. A behavioural model samples old register values before it applies writes, and it judges bus_rdata and every pad output against that model on every falling edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_LATCH = 2'd0,
    REG_DIR   = 2'd1,
    REG_PULL  = 2'd2,
    REG_SLEW  = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [STAGES-1:0][W-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  input  logic              bus_rd,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_sync,
  output logic [W-1:0]      latch_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      pull_q,
  output logic [W-1:0]      slew_q
);
  logic [W-1:0] latch_view;
  logic [W-1:0] rd_mux;
  gpio_reg_e    sel;

  assign sel = gpio_reg_e'(bus_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      pull_q  <= '0;
      slew_q  <= '0;
    end else if (bus_wr) begin
      case (sel)
        REG_LATCH: latch_q <= bus_wdata;
        REG_DIR:   dir_q   <= bus_wdata;
        REG_PULL:  pull_q  <= bus_wdata;
        default:   slew_q  <= bus_wdata;
      endcase
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_view
    assign latch_view[i] = dir_q[i] ? latch_q[i] : pin_sync[i];
  end

  always_comb begin
    case (sel)
      REG_LATCH: rd_mux = latch_view;
      REG_DIR:   rd_mux = dir_q;
      REG_PULL:  rd_mux = pull_q;
      default:   rd_mux = slew_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_latch_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_LATCH) |=> latch_q == $past(bus_wdata));

  assert_read_dir_old_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == REG_DIR) |=> bus_rdata == $past(dir_q));

  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int W        = 8,
  parameter int KBD_PINS = 4
) (
  input  logic [W-1:0]        latch_q,
  input  logic [W-1:0]        dir_q,
  input  logic [W-1:0]        pull_q,
  input  logic [W-1:0]        slew_q,
  input  logic [W-1:0]        per_own,
  input  logic [W-1:0]        per_oe,
  input  logic [W-1:0]        per_out,
  input  logic [KBD_PINS-1:0] kbd_rise,
  output logic [W-1:0]        pad_oe,
  output logic [W-1:0]        pad_out,
  output logic [W-1:0]        pad_pu,
  output logic [W-1:0]        pad_pd,
  output logic [W-1:0]        pad_slew
);
  localparam int KBD_LO = W - KBD_PINS;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic drive;
    logic pull_on;

    assign drive       = per_own[i] ? per_oe[i]  : dir_q[i];
    assign pad_oe[i]   = drive;
    assign pad_out[i]  = per_own[i] ? per_out[i] : latch_q[i];
    assign pull_on     = pull_q[i] & ~dir_q[i] & ~drive;
    assign pad_slew[i] = slew_q[i] & drive;

    if (i >= KBD_LO) begin : g_kbd
      assign pad_pd[i] = pull_on & kbd_rise[i-KBD_LO];
      assign pad_pu[i] = pull_on & ~kbd_rise[i-KBD_LO];
    end else begin : g_plain
      assign pad_pd[i] = 1'b0;
      assign pad_pu[i] = pull_on;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int W        = 8,
  parameter int KBD_PINS = 4,
  parameter int SYNC_STG = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [W-1:0]        bus_wdata,
  input  logic                bus_rd,
  output logic [W-1:0]        bus_rdata,
  input  logic [W-1:0]        pin_in,
  input  logic [W-1:0]        per_own,
  input  logic [W-1:0]        per_oe,
  input  logic [W-1:0]        per_out,
  input  logic [KBD_PINS-1:0] kbd_rise,
  output logic [W-1:0]        pad_oe,
  output logic [W-1:0]        pad_out,
  output logic [W-1:0]        pad_pu,
  output logic [W-1:0]        pad_pd,
  output logic [W-1:0]        pad_slew
);
  logic [W-1:0] pin_sync;
  logic [W-1:0] latch_q, dir_q, pull_q, slew_q;

  gpio_sync #(.W(W), .STAGES(SYNC_STG)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_sync  (pin_sync),
    .latch_q   (latch_q),
    .dir_q     (dir_q),
    .pull_q    (pull_q),
    .slew_q    (slew_q)
  );

  gpio_pad_ctl #(.W(W), .KBD_PINS(KBD_PINS)) u_pad (
    .latch_q  (latch_q),
    .dir_q    (dir_q),
    .pull_q   (pull_q),
    .slew_q   (slew_q),
    .per_own  (per_own),
    .per_oe   (per_oe),
    .per_out  (per_out),
    .kbd_rise (kbd_rise),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .pad_pu   (pad_pu),
    .pad_pd   (pad_pd),
    .pad_slew (pad_slew)
  );

  // Pad controls checked against register state held in a separate module
  assert_own_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ dir_q) & ~per_own) == '0);

  assert_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ per_oe) & per_own) == '0);

  assert_pull_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu | pad_pd) & (dir_q | pad_oe | ~pull_q)) == '0);

  assert_pull_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  assert_slew_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_slew & ~(pad_oe & slew_q)) == '0);
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] per_own = '0;
  logic [7:0] per_oe = '0;
  logic [7:0] per_out = '0;
  logic [3:0] kbd_rise = '0;
  logic [7:0] pad_oe, pad_out, pad_pu, pad_pd, pad_slew;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // 125 MHz
  always #4 clk = ~clk;

  gpio_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .per_own(per_own), .per_oe(per_oe), .per_out(per_out),
    .kbd_rise(kbd_rise), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .pad_slew(pad_slew)
  );

  // Behavioural reference model
  logic [7:0] m_latch, m_dir, m_pull, m_slew, m_rdata;
  logic [7:0] m_pins[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_latch = 0; m_dir = 0; m_pull = 0; m_slew = 0; m_rdata = 0;
      m_pins = {8'h00, 8'h00};
    end else begin
      logic [7:0] seen;
      seen = m_pins[0];
      if (bus_rd) begin
        case (bus_addr)
          2'd0: m_rdata = (m_dir & m_latch) | (~m_dir & seen);
          2'd1: m_rdata = m_dir;
          2'd2: m_rdata = m_pull;
          default: m_rdata = m_slew;
        endcase
      end
      if (bus_wr) begin
        case (bus_addr)
          2'd0: m_latch = bus_wdata;
          2'd1: m_dir = bus_wdata;
          2'd2: m_pull = bus_wdata;
          default: m_slew = bus_wdata;
        endcase
      end
      void'(m_pins.pop_front());
      m_pins.push_back(pin_in);
    end
  end

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string phase);
    logic [7:0] e_oe, e_out, e_pu, e_pd, e_slew;
    for (int i = 0; i < 8; i++) begin
      logic pull_on;
      e_oe[i]   = per_own[i] ? per_oe[i] : m_dir[i];
      e_out[i]  = per_own[i] ? per_out[i] : m_latch[i];
      pull_on   = m_pull[i] && !m_dir[i] && !e_oe[i];
      e_pd[i]   = (i >= 4) ? (pull_on && kbd_rise[i-4]) : 1'b0;
      e_pu[i]   = pull_on && !e_pd[i];
      e_slew[i] = m_slew[i] && e_oe[i];
    end
    chk({phase, " R3 R4 R10"}, "bus_rdata", bus_rdata, m_rdata);
    chk({phase, " R5 R6"}, "pad_oe", pad_oe, e_oe);
    chk({phase, " R5 R6"}, "pad_out", pad_out, e_out);
    chk({phase, " R7 R8"}, "pad_pu", pad_pu, e_pu);
    chk({phase, " R8"}, "pad_pd", pad_pd, e_pd);
    chk({phase, " R9"}, "pad_slew", pad_slew, e_slew);
  endtask

  task automatic cyc(string phase, logic wr, logic rd, logic [1:0] a, logic [7:0] d);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    compare_all(phase);
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    pin_in = 8'h3C;
    per_own = 8'hFF; per_oe = 8'h0F; per_out = 8'hAA;
    @(negedge clk);
    rst_n = 1;
    per_own = 0; per_oe = 0; per_out = 0;
    cyc("R1 after reset", 0, 0, 0, 0);
    // R2 latch write while input, then reads
    cyc("R2", 1, 0, 2'd0, 8'hA5);
    cyc("R2", 0, 1, 2'd0, 8'h00);
    cyc("R2", 1, 0, 2'd1, 8'hF0);
    cyc("R4", 0, 1, 2'd0, 8'h00);
    // R4 synchronizer latency
    pin_in = 8'h0F;
    cyc("R4 sync1", 0, 1, 2'd0, 8'h00);
    cyc("R4 sync2", 0, 1, 2'd0, 8'h00);
    cyc("R4 sync3", 0, 1, 2'd0, 8'h00);
    // R10 same-edge collisions on every address
    for (int a = 0; a < 4; a++) cyc("R10", 1, 1, a[1:0], 8'h5A ^ 8'(a));
    cyc("R10", 0, 1, 2'd1, 8'h00);
    cyc("R10 dir vs latch", 1, 0, 2'd1, 8'h00);
    cyc("R10 dir vs latch", 1, 1, 2'd1, 8'hFF);
    cyc("R10 dir vs latch", 0, 1, 2'd0, 8'h00);
    // R5 override, data read still selected by direction
    per_own = 8'hC3; per_oe = 8'h41; per_out = 8'h82;
    cyc("R5", 1, 0, 2'd0, 8'h66);
    cyc("R5", 0, 1, 2'd0, 8'h00);
    cyc("R5", 1, 0, 2'd1, 8'h0F);
    cyc("R5", 0, 1, 2'd0, 8'h00);
    // R7 R8 pulls with keyboard polarity, R9 slew
    cyc("R7", 1, 0, 2'd2, 8'hFF);
    kbd_rise = 4'b1010;
    cyc("R8", 1, 0, 2'd1, 8'h00);
    per_own = 0;
    cyc("R8", 0, 0, 2'd0, 8'h00);
    kbd_rise = 4'b0101;
    cyc("R8", 1, 0, 2'd3, 8'hFF);
    cyc("R9", 1, 0, 2'd1, 8'h33);
    per_own = 8'h0C; per_oe = 8'h04;
    cyc("R9", 0, 0, 2'd0, 8'h00);
    // Random mix
    for (int k = 0; k < 4000; k++) begin
      pin_in   = 8'($urandom);
      per_own  = 8'($urandom) & 8'($urandom);
      per_oe   = 8'($urandom);
      per_out  = 8'($urandom);
      kbd_rise = 4'($urandom);
      cyc("RND R2", 1'($urandom), 1'($urandom), 2'($urandom), 8'($urandom));
    end
    summary();
  end
endmodule